// File: doc/BRIEF.md
# Per-Frame Configurable SPI Master

This block is an SPI bus master for a chip subsystem that talks to up to six serial peripherals. Software-side logic writes up to eight attribute sets into a small register bank. Each set holds a frame length, clock polarity, clock phase, shift direction and clock divider. Work is then queued into a four-entry transmit queue. Every queued entry carries the data word, a 3-bit selector naming the attribute set to use, and a 6-bit mask of the peripheral selects to drive. Because each entry names its own set, neighbouring frames can differ in length, mode, order and speed.

For each frame the block pops one entry and latches the chosen set. It lowers the requested selects and runs the serial clock. It shifts the word out while shifting the peripheral's reply in, then raises the selects and stores the reply, right-justified, in a four-entry receive queue. A master-enable input and a module-disable input gate all activity, and turning either off aborts a frame in flight. A device-level debug input lets the current frame finish and then holds off new frames.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset all select outputs are high, SCK is 0, the transmit queue reports not full and the receive queue reports empty.
- R2: An attribute write stores `attr_wdata` into set `attr_idx`, with this layout: bits [3:0] hold frame length minus one, bit 4 is CPOL, bit 5 is CPHA, bit 6 selects LSB-first and bits [14:7] hold the divider. A length field below 3 gives a 4-bit frame. Each frame uses the set named by its entry's `tx_sel` and makes exactly two SCK edges per bit. SCK is at the set's CPOL level when the selects drop, and SCK holds its level between frames.
- R3: With CPHA 0 the first bit is on SOUT when the selects drop, SIN is sampled on odd-numbered SCK edges (1st, 3rd, ...) and SOUT changes on even-numbered edges. With CPHA 1, SOUT changes on odd-numbered edges and SIN is sampled on even-numbered edges. The received word enters the receive queue right-justified, with unused upper bits zero.
- R4: Bits are sent and received most significant first, or least significant first when the set's LSB-first bit is 1.
- R5: Every SCK half period, the time from selects dropping to the first SCK edge, and the time from the last edge to selects rising each last divider+1 clocks.
- R6: During a frame, `cs_n[i]` is low exactly when bit i of the entry's `tx_cs` is 1. The select pattern is stable for the whole frame, and all selects are high for at least one clock between frames.
- R7: The transmit queue holds 4 entries. `tx_full` is 1 when it holds 4, and a push while full is dropped.
- R8: The receive queue holds 4 words, popped in frame order by `rx_pop`. A frame starts only if the receive queue is not full.
- R9: While `ctl_master_en` is 0 or `ctl_disable` is 1, no frame starts. A frame in flight is abandoned on the next clock without writing the receive queue, all selects go high and SCK goes to the CPOL level of the last set used.
- R10: While `dbg_halt` is 1, a frame already running completes and stores its reply, but no new frame starts until `dbg_halt` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_master_en | input | 1 | Master enable; frames run only while 1 |
| ctl_disable | input | 1 | Module disable; halts all transfers |
| dbg_halt | input | 1 | Device debug request; stops new frames |
| attr_we | input | 1 | Write strobe for the attribute bank |
| attr_idx | input | 3 | Attribute set being written |
| attr_wdata | input | 15 | Attribute value (layout in R2) |
| tx_push | input | 1 | Push one entry into the transmit queue |
| tx_data | input | 16 | Data word of the entry |
| tx_sel | input | 3 | Attribute set selector of the entry |
| tx_cs | input | 6 | Select mask of the entry, 1 = assert |
| tx_full | output | 1 | Transmit queue holds 4 entries |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_empty | output | 1 | Receive queue holds no word |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data to peripherals |
| sin | input | 1 | Serial data from peripherals |
| cs_n | output | 6 | Active-low peripheral selects |

## Verification
The hardest conditions to reach are the stalls: a frame held back because the receive queue is full while transmit work waits, and a debug request landing in the middle of a frame. The bench reaches the first by queuing entries while the master is turned off, letting four frames fill the receive queue without draining it, and then pushing a fifth entry. It reaches the second by raising debug only once the selects have dropped. A behavioural peripheral model, driven from the expected attribute table, checks every frame of a sweep over all eight attribute sets. The sweep covers all four polarity and phase pairs, both bit orders, several dividers and the clamped short length.

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int DW    = 16,
  parameter int NCS   = 6,
  parameter int NSET  = 8,
  parameter int DEPTH = 4,
  parameter int DIVW  = 8,
  localparam int SW   = $clog2(NSET),
  localparam int FW   = $clog2(DW),
  localparam int ATW  = FW + 3 + DIVW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_master_en,
  input  logic           ctl_disable,
  input  logic           dbg_halt,
  input  logic           attr_we,
  input  logic [SW-1:0]  attr_idx,
  input  logic [ATW-1:0] attr_wdata,
  input  logic           tx_push,
  input  logic [DW-1:0]  tx_data,
  input  logic [SW-1:0]  tx_sel,
  input  logic [NCS-1:0] tx_cs,
  output logic           tx_full,
  input  logic           rx_pop,
  output logic [DW-1:0]  rx_data,
  output logic           rx_empty,
  output logic           sck,
  output logic           sout,
  input  logic           sin,
  output logic [NCS-1:0] cs_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = NCS + SW + DW;

  typedef enum logic [1:0] {IDLE, RUN, TRAIL} st_t;
  st_t st;

  logic [ATW-1:0]  attr_q [NSET];
  logic [EW-1:0]   txm [DEPTH];
  logic [DW-1:0]   rxm [DEPTH];
  logic [AW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]     tx_cnt, rx_cnt;
  logic [ATW-1:0]  cur, nxt;
  logic [DW-1:0]   word, rx_sh, rx_word;
  logic [DIVW-1:0] cnt;
  logic [FW:0]     k, bi;
  logic [FW-1:0]   c_nm1, n_nm1;
  logic [EW-1:0]   head;

  function automatic logic [FW-1:0] len_m1(input logic [FW-1:0] f);
    return (f < FW'(3)) ? FW'(3) : f;
  endfunction

  function automatic logic pick(input logic [DW-1:0] w, input logic [FW-1:0] i,
                                input logic [FW-1:0] m, input logic lsb);
    return lsb ? w[i] : w[m - i];
  endfunction

  wire run    = ctl_master_en & ~ctl_disable;
  wire tick   = (cnt == '0);
  wire start  = (st == IDLE) && run && !dbg_halt && (tx_cnt != '0) &&
                (rx_cnt != (AW+1)'(DEPTH));
  wire tx_wr  = tx_push && !tx_full;
  wire rx_wr  = (st == TRAIL) && tick && run;
  wire rx_rd  = rx_pop && !rx_empty;
  wire c_cpol = cur[FW];
  wire c_cpha = cur[FW+1];
  wire c_lsb  = cur[FW+2];
  wire [DIVW-1:0] c_div = cur[ATW-1 -: DIVW];

  assign head     = txm[tx_rp];
  assign nxt      = attr_q[head[DW +: SW]];
  assign n_nm1    = len_m1(nxt[FW-1:0]);
  assign c_nm1    = len_m1(cur[FW-1:0]);
  assign tx_full  = (tx_cnt == (AW+1)'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rx_data  = rxm[rx_rp];

  always_comb begin
    rx_word = '0;
    for (int i = 0; i < DW; i++)
      if (i <= int'(c_nm1))
        rx_word[i] = c_lsb ? rx_sh[int'(c_nm1) - i] : rx_sh[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSET; s++) attr_q[s] <= '0;
    end else if (attr_we) begin
      attr_q[attr_idx] <= attr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_wr) txm[tx_wp] <= {tx_cs, tx_sel, tx_data};
    if (rx_wr) rxm[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + 1'b1;
      if (start) tx_rp <= tx_rp + 1'b1;
      if (rx_wr) rx_wp <= rx_wp + 1'b1;
      if (rx_rd) rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + (AW+1)'(tx_wr) - (AW+1)'(start);
      rx_cnt <= rx_cnt + (AW+1)'(rx_wr) - (AW+1)'(rx_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cur <= '0; word <= '0; rx_sh <= '0; cnt <= '0;
      k <= '0; bi <= '0; sck <= 1'b0; sout <= 1'b0; cs_n <= '1;
    end else if (st != IDLE && !run) begin
      st <= IDLE; cs_n <= '1; sck <= c_cpol;
    end else begin
      case (st)
        IDLE: if (start) begin
          st    <= RUN;
          cur   <= nxt;
          word  <= head[DW-1:0];
          cs_n  <= ~head[EW-1 -: NCS];
          sck   <= nxt[FW];
          cnt   <= nxt[ATW-1 -: DIVW];
          k     <= '0;
          rx_sh <= '0;
          if (!nxt[FW+1]) begin
            sout <= pick(head[DW-1:0], '0, n_nm1, nxt[FW+2]);
            bi   <= (FW+1)'(1);
          end else begin
            bi   <= '0;
          end
        end
        RUN: if (tick) begin
          sck <= ~sck;
          cnt <= c_div;
          k   <= k + 1'b1;
          if (k[0] == c_cpha) begin
            rx_sh <= {rx_sh[DW-2:0], sin};
          end else if (bi <= {1'b0, c_nm1}) begin
            sout <= pick(word, bi[FW-1:0], c_nm1, c_lsb);
            bi   <= bi + 1'b1;
          end
          if (k == {c_nm1, 1'b1}) st <= TRAIL;
        end else begin
          cnt <= cnt - 1'b1;
        end
        TRAIL: if (tick) begin
          st   <= IDLE;
          cs_n <= '1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
  parameter int NCS   = 6,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_master_en,
  input logic           ctl_disable,
  input logic           dbg_halt,
  input logic           sck,
  input logic [NCS-1:0] cs_n,
  input logic [AW:0]    tx_cnt,
  input logic [AW:0]    rx_cnt
);
  wire off  = !ctl_master_en || ctl_disable;
  wire idle = &cs_n;

  assert_off_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> idle);

  assert_cs_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> $stable(cs_n));

  assert_sck_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle)) |-> $stable(sck));

  assert_debug_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && idle) |=> idle);

  assert_tx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (AW+1)'(DEPTH));

  assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= (AW+1)'(DEPTH));
endmodule

bind spi_cmd_master spi_cmd_master_chk #(.NCS(NCS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_master_en(ctl_master_en),
  .ctl_disable(ctl_disable), .dbg_halt(dbg_halt), .sck(sck), .cs_n(cs_n),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_cmd_master_tb.sv
module spi_cmd_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, dis = 1'b0, dbg = 1'b0;
  logic attr_we = 1'b0;
  logic [2:0] attr_idx = '0;
  logic [14:0] attr_wd = '0;
  logic tx_push = 1'b0;
  logic [15:0] tx_data = '0;
  logic [2:0] tx_sel = '0;
  logic [5:0] tx_cs = '0;
  logic tx_full, rx_empty, sck, sout;
  logic rx_pop = 1'b0;
  logic [15:0] rx_data;
  logic sin_r = 1'b0;
  logic [5:0] cs_n;

  always #2 clk = ~clk;

  spi_cmd_master u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_master_en(en), .ctl_disable(dis),
    .dbg_halt(dbg), .attr_we(attr_we), .attr_idx(attr_idx),
    .attr_wdata(attr_wd), .tx_push(tx_push), .tx_data(tx_data),
    .tx_sel(tx_sel), .tx_cs(tx_cs), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_empty(rx_empty), .sck(sck), .sout(sout),
    .sin(sin_r), .cs_n(cs_n)
  );

  int nchk = 0, nerr = 0, fn = 0;
  logic [15:0] e_tx [64];
  logic [15:0] e_sl [64];
  int          e_sel [64];
  logic [5:0]  e_cs [64];
  bit abort_exp = 1'b0;

  function automatic int fld(int i);
    case (i)
      0: return 3;  1: return 15; 2: return 7; 3: return 0;
      4: return 11; 5: return 4;  6: return 9; default: return 15;
    endcase
  endfunction
  function automatic int nbits(int i); return (fld(i) < 3) ? 4 : fld(i) + 1; endfunction
  function automatic int cpol(int i); return i & 1; endfunction
  function automatic int cpha(int i); return (i >> 1) & 1; endfunction
  function automatic int lsbf(int i); return (i >> 2) & 1; endfunction
  function automatic int divv(int i); return i % 4; endfunction
  function automatic logic [14:0] aword(int i);
    return 15'(fld(i) | (cpol(i) << 4) | (cpha(i) << 5) | (lsbf(i) << 6) | (divv(i) << 7));
  endfunction
  function automatic logic [15:0] lowmask(int n); return 16'((1 << n) - 1); endfunction
  function automatic logic bitof(logic [15:0] w, int s, int i);
    return lsbf(s) ? w[i] : w[nbits(s) - 1 - i];
  endfunction
  function automatic logic [15:0] seq(int n);
    logic [15:0] r = '0;
    for (int i = 0; i < nbits(e_sel[n]); i++) r = {r[14:0], bitof(e_tx[n], e_sel[n], i)};
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prep(int n, int s);
    e_sel[n] = s;
    e_tx[n]  = 16'(n * 40503 + 12345);
    e_sl[n]  = 16'((n * 9973) ^ 16'h5A3C);
    e_cs[n]  = 6'((1 << (n % 6)) | ((n * 13) & 63));
  endtask

  task automatic push(int n, bit wait_space);
    while (wait_space && tx_full) @(negedge clk);
    tx_push = 1'b1; tx_data = e_tx[n]; tx_sel = 3'(e_sel[n]); tx_cs = e_cs[n];
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic popchk(int n, string tag);
    logic [15:0] ex;
    while (rx_empty) @(negedge clk);
    ex = e_sl[n] & lowmask(nbits(e_sel[n]));
    chk(rx_data == ex, tag, int'(rx_data), int'(ex));
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  bit pact = 1'b0, act;
  logic psck = 1'b0;
  int cyc = 0, ec = 0, si = 0, cur = 0;
  bit tok = 1'b1;
  logic [15:0] cap = '0;
  logic [5:0] mcs = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      act = !(&cs_n);
      cyc++;
      if (act && !pact) begin
        cur = e_sel[fn]; cyc = 0; ec = 0; si = 0; cap = '0; tok = 1'b1; mcs = cs_n;
        chk(int'(sck) == cpol(cur), "R2 SCK at CPOL when selects drop", int'(sck), cpol(cur));
        if (cpha(cur) == 0) begin sin_r = bitof(e_sl[fn], cur, 0); si = 1; end
      end else if (act && sck != psck) begin
        if (cyc != divv(cur) + 1) tok = 1'b0;
        cyc = 0;
        if ((ec % 2) == cpha(cur)) cap = {cap[14:0], sout};
        else if (si < nbits(cur)) begin sin_r = bitof(e_sl[fn], cur, si); si++; end
        ec++;
      end else if (!act && pact) begin
        if (!abort_exp) begin
          chk(tok && cyc == divv(cur) + 1, "R5 half period, lead and lag", cyc, divv(cur) + 1);
          chk(ec == 2 * nbits(cur), "R2 edges per frame", ec, 2 * nbits(cur));
          chk(mcs == ~e_cs[fn], "R6 select pattern", int'(mcs), int'(~e_cs[fn]));
          chk(cap == seq(fn), "R3 R4 serial output bits", int'(cap), int'(seq(fn)));
        end
        fn++;
      end
      pact = act;
      psck = sck;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog (all requirements): actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 6'h3F, "R1 selects high in reset", int'(cs_n), 'h3F);
    chk(sck == 1'b0, "R1 SCK low in reset", int'(sck), 0);
    chk(tx_full == 1'b0, "R1 tx not full", int'(tx_full), 0);
    chk(rx_empty == 1'b1, "R1 rx empty", int'(rx_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      attr_we = 1'b1; attr_idx = 3'(i); attr_wd = aword(i);
      @(negedge clk);
    end
    attr_we = 1'b0;
    en = 1'b1;

    fork
      begin
        for (int n = 0; n < 16; n++) begin prep(n, n % 8); push(n, 1'b1); end
      end
      begin
        for (int n = 0; n < 16; n++) popchk(n, "R3 R8 received word in order");
      end
    join

    while (fn < 16) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int n = 16; n < 20; n++) begin prep(n, n % 4); push(n, 1'b0); end
    chk(tx_full == 1'b1, "R7 full after four entries", int'(tx_full), 1);
    tx_push = 1'b1; tx_data = 16'hFFFF; tx_sel = 3'd1; tx_cs = 6'h3F;
    @(negedge clk);
    tx_push = 1'b0;
    repeat (100) @(negedge clk);
    chk(fn == 16, "R9 no frame while master enable clear", fn, 16);
    chk(cs_n == 6'h3F, "R9 selects high while off", int'(cs_n), 'h3F);
    chk(sck == 1'b1, "R9 SCK holds CPOL of last set", int'(sck), 1);
    en = 1'b1; dis = 1'b1;
    repeat (100) @(negedge clk);
    chk(fn == 16, "R9 no frame while disabled", fn, 16);
    dis = 1'b0;
    while (fn < 20) @(negedge clk);
    prep(20, 4);
    push(20, 1'b1);
    repeat (400) @(negedge clk);
    chk(fn == 20, "R8 start held while rx full", fn, 20);
    chk(cs_n == 6'h3F, "R8 selects high while held", int'(cs_n), 'h3F);
    for (int n = 16; n < 20; n++) popchk(n, "R7 queued entries in order");
    popchk(20, "R7 push while full dropped");

    prep(21, 7); prep(22, 7);
    push(21, 1'b1); push(22, 1'b1);
    while (&cs_n) @(negedge clk);
    dbg = 1'b1;
    while (fn < 22) @(negedge clk);
    repeat (300) @(negedge clk);
    chk(fn == 22, "R10 no new frame during debug", fn, 22);
    chk(cs_n == 6'h3F, "R10 selects high during debug", int'(cs_n), 'h3F);
    popchk(21, "R10 frame in flight completed");
    dbg = 1'b0;
    while (fn < 23) @(negedge clk);
    popchk(22, "R10 frames resume after debug");

    prep(23, 5);
    push(23, 1'b1);
    while (&cs_n) @(negedge clk);
    repeat (6) @(negedge clk);
    abort_exp = 1'b1; dis = 1'b1;
    @(negedge clk);
    chk(cs_n == 6'h3F, "R9 abort raises selects", int'(cs_n), 'h3F);
    chk(sck == 1'b1, "R9 SCK to CPOL on abort", int'(sck), 1);
    repeat (60) @(negedge clk);
    chk(rx_empty == 1'b1, "R9 aborted frame stores nothing", int'(rx_empty), 1);
    dis = 1'b0; abort_exp = 1'b0;
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule